// File: doc/BRIEF.md
# Two-Tier Secondary Bus Arbiter

This block decides which master may drive the secondary PCI bus. It serves nine external masters, each with an active-low request and grant pin pair, and the bridge's own master port, which uses a plain active-high request and grant inside the chip. That makes ten requesters. Each requester has a tier bit. Requesters with the bit set rotate among themselves in round-robin order. All requesters with the bit clear share a single slot in that rotation, and inside that slot they rotate among themselves as well. When nobody is requesting, the grant rests on the bridge.

A grant moves only when the bus is idle or after the current owner has started its transaction. Every move passes through at least one clock with no grant asserted. When the external-arbiter enable is high, the internal arbiter is held cleared and pin pair 0 changes role. The request pin 0 becomes the bridge's grant input from an outside arbiter. The grant pin 0 becomes the bridge's request output to that arbiter. Both are registered.

Top module: `pci_tier_arbiter`

## Requirements
- R1: While `rst_n` is sampled low, every bit of `gnt_pin_n` (pin 0 included) is driven high and `brg_gnt` is driven low from the next clock edge on.
- R2: In internal mode with no request pending, the bridge (slot 0, `brg_gnt`) holds the grant.
- R3: In internal mode at most one of `brg_gnt` and the low bits of `gnt_pin_n` is asserted in any cycle.
- R4: Between two different owners there is at least one cycle in which no grant is asserted.
- R5: The requesters whose tier bit is 1 are granted in round-robin order, starting after the most recently granted tier-1 slot. Slot 0 is the bridge and slot k+1 is pin k. After reset the search starts from slot 0.
- R6: All requesters whose tier bit is 0 together take one turn in the tier-1 rotation, placed after slot 9. Each such turn goes to the next tier-0 requester after the last tier-0 requester that was granted.
- R7: A grant is withdrawn only on a clock edge where `frame_n` and `irdy_n` are both high, or after `frame_n` has been sampled low while that owner held the grant. Otherwise the grant is held.
- R8: In external mode (`ext_arb_en` high on the previous edge), `gnt_pin_n[8:1]` are all high and `req_pin_n[8:1]` have no effect.
- R9: In external mode, `gnt_pin_n[0]` equals the inverse of `brg_req` and `brg_gnt` equals the inverse of `req_pin_n[0]`, each as sampled on the previous clock edge.
- R10: When an idle bus is parked on the bridge and a single pin request arrives, the grant is withdrawn on the first edge that samples the request. The pin is granted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Synchronous active-low secondary reset |
| ext_arb_en | input | 1 | High selects external-arbiter mode |
| tier_hi | input | 10 | Tier bit per slot (slot 0 bridge, slot k+1 pin k), 1 = upper tier |
| frame_n | input | 1 | Bus frame, active low, monitored |
| irdy_n | input | 1 | Bus initiator ready, active low, monitored |
| req_pin_n | input | 9 | Master requests, active low; pin 0 is the outside grant in external mode |
| gnt_pin_n | output | 9 | Master grants, active low; pin 0 is the bridge request in external mode |
| brg_req | input | 1 | Bridge master port request, active high |
| brg_gnt | output | 1 | Bridge master port grant, active high |

## Verification
The properties assume that `tier_hi` and the mode input change only while no transaction depends on the outcome. They also assume that `frame_n` is low only while some master actually owns the bus, so that a low frame really marks the start of a transaction by the grant holder. The withdrawal property watches frame during each ownership with its own flag, so it relies on frame not being left low from an earlier owner. The stimulus drives `frame_n` low only in the hold scenario, while a single owner is granted. In every other scenario it keeps the bus idle and changes the tier bits only while reset is held.

// File: rtl/pci_arb_pkg.sv
// Package: shared types and helpers for the two-tier bus arbiter.
// Assumes: bus control signals are active low, as on a PCI bus.
package pci_arb_pkg;

    typedef enum logic {
        ARB_INTERNAL = 1'b0,
        ARB_EXTERNAL = 1'b1
    } arb_mode_e;

    // True when neither frame nor initiator-ready is asserted.
    function automatic logic bus_is_idle(input logic frame_n, input logic irdy_n);
        return frame_n && irdy_n;
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
// Module: round-robin picker. Returns the first set request strictly after
// position 'last', wrapping around. Purely combinational.
// Assumes: last < W.
module arb_rr_pick #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan positions last+1 .. last+W modulo W and keep the first hit.
    always_comb begin
        found = 1'b0;
        idx   = last;
        for (int k = 1; k <= W; k++) begin
            if (!found && req[(int'(last) + k) % W]) begin
                found = 1'b1;
                idx   = IW'((int'(last) + k) % W);
            end
        end
    end

endmodule

// File: rtl/arb_tier_select.sv
// Module: two-tier winner selection. The upper-tier rotation has one extra
// slot (index NR) that stands for the whole lower tier. The lower tier
// rotates within that slot.
// Assumes: pointers are kept by the caller and updated only on a grant.
module arb_tier_select #(
    parameter int NR = 10,
    parameter int HW = $clog2(NR + 1),
    parameter int LW = $clog2(NR)
) (
    input  logic [NR-1:0] req,
    input  logic [NR-1:0] tier_hi,
    input  logic [HW-1:0] last_hi,
    input  logic [LW-1:0] last_lo,
    output logic          win_valid,
    output logic          win_from_lo,
    output logic [LW-1:0] win_idx
);

    logic [NR-1:0] lo_req;
    logic [NR:0]   hi_vec;
    logic          hi_found;
    logic [HW-1:0] hi_idx;
    logic          lo_found;
    logic [LW-1:0] lo_idx;

    // Split requests by tier; the lower tier shows up as one upper slot.
    always_comb begin
        lo_req = req & ~tier_hi;
        hi_vec = {|lo_req, req & tier_hi};
    end

    arb_rr_pick #(.W(NR + 1), .IW(HW)) u_hi_pick (
        .req   (hi_vec),
        .last  (last_hi),
        .found (hi_found),
        .idx   (hi_idx)
    );

    arb_rr_pick #(.W(NR), .IW(LW)) u_lo_pick (
        .req   (lo_req),
        .last  (last_lo),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // Resolve the lower-tier slot into a concrete requester.
    always_comb begin
        win_valid   = 1'b0;
        win_from_lo = 1'b0;
        win_idx     = '0;
        if (hi_found) begin
            win_valid = 1'b1;
            if (hi_idx == HW'(NR)) begin
                win_from_lo = 1'b1;
                win_idx     = lo_idx;
                win_valid   = lo_found;
            end else begin
                win_idx = LW'(hi_idx);
            end
        end
    end

endmodule

// File: rtl/arb_grant_ctrl.sv
// Module: grant owner register and handover control. It holds one-hot
// ownership, inserts an empty cycle on every change, and parks on slot 0
// when idle.
// Assumes: 'clr' is high for as long as the internal arbiter is bypassed.
module arb_grant_ctrl
    import pci_arb_pkg::*;
#(
    parameter int NR = 10,
    parameter int HW = $clog2(NR + 1),
    parameter int LW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NR-1:0] req,
    input  logic [NR-1:0] tier_hi,
    input  logic          frame_n,
    input  logic          irdy_n,
    output logic [NR-1:0] owner
);

    logic [NR-1:0] owner_q;
    logic          started_q;
    logic [HW-1:0] last_hi_q;
    logic [LW-1:0] last_lo_q;
    logic          win_valid;
    logic          win_from_lo;
    logic [LW-1:0] win_idx;
    logic [NR-1:0] win_oh;
    logic          may_move;

    arb_tier_select #(.NR(NR), .HW(HW), .LW(LW)) u_sel (
        .req         (req),
        .tier_hi     (tier_hi),
        .last_hi     (last_hi_q),
        .last_lo     (last_lo_q),
        .win_valid   (win_valid),
        .win_from_lo (win_from_lo),
        .win_idx     (win_idx)
    );

    // Target owner: the winner, or the bridge (slot 0) when nobody asks.
    always_comb begin
        win_oh   = win_valid ? (NR'(1) << win_idx) : NR'(1);
        may_move = bus_is_idle(frame_n, irdy_n) || started_q;
    end

    // Ownership, transaction-start tracking and rotation pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owner_q   <= '0;
            started_q <= 1'b0;
            last_hi_q <= HW'(NR);
            last_lo_q <= LW'(NR - 1);
        end else if (owner_q == '0) begin
            owner_q   <= win_oh;
            started_q <= 1'b0;
            if (win_valid) begin
                if (win_from_lo) begin
                    last_hi_q <= HW'(NR);
                    last_lo_q <= win_idx;
                end else begin
                    last_hi_q <= HW'(win_idx);
                end
            end
        end else if (owner_q != win_oh && may_move) begin
            owner_q   <= '0;
            started_q <= 1'b0;
        end else if (!frame_n) begin
            started_q <= 1'b1;
        end
    end

    assign owner = owner_q;

endmodule

// File: rtl/arb_ext_link.sv
// Module: registered request/grant link to an outside arbiter, used in
// external mode on pin pair 0.
// Assumes: the outside grant is synchronous to clk.
module arb_ext_link (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_en,
    input  logic brg_req,
    input  logic gnt_in_n,
    output logic req_out_n,
    output logic brg_gnt
);

    // Sample the bridge request out and the outside grant in.
    always_ff @(posedge clk) begin
        if (!rst_n || !ext_en) begin
            req_out_n <= 1'b1;
            brg_gnt   <= 1'b0;
        end else begin
            req_out_n <= ~brg_req;
            brg_gnt   <= ~gnt_in_n;
        end
    end

endmodule

// File: rtl/pci_tier_arbiter.sv
// Module: top of the two-tier secondary bus arbiter. Slot 0 is the bridge,
// slot k+1 is pin pair k. In external mode pin pair 0 carries the bridge's
// own request out and grant in.
// Assumes: ext_arb_en and tier_hi are quasi-static.
module pci_tier_arbiter
    import pci_arb_pkg::*;
#(
    parameter int N_EXT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_arb_en,
    input  logic [N_EXT:0]   tier_hi,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [N_EXT-1:0] req_pin_n,
    output logic [N_EXT-1:0] gnt_pin_n,
    input  logic             brg_req,
    output logic             brg_gnt
);

    localparam int NR = N_EXT + 1;

    arb_mode_e     mode_q;
    logic [NR-1:0] req_vec;
    logic [NR-1:0] owner;
    logic          link_req_n;
    logic          link_gnt;

    // Registered operating mode, so outputs switch on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ARB_INTERNAL;
        else        mode_q <= ext_arb_en ? ARB_EXTERNAL : ARB_INTERNAL;
    end

    // Gather requests into slot order.
    always_comb req_vec = {~req_pin_n, brg_req};

    arb_grant_ctrl #(.NR(NR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ext_arb_en),
        .req     (req_vec),
        .tier_hi (tier_hi),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .owner   (owner)
    );

    arb_ext_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_arb_en),
        .brg_req   (brg_req),
        .gnt_in_n  (req_pin_n[0]),
        .req_out_n (link_req_n),
        .brg_gnt   (link_gnt)
    );

    // Route pins by mode.
    always_comb begin
        if (mode_q == ARB_EXTERNAL) begin
            gnt_pin_n    = '1;
            gnt_pin_n[0] = link_req_n;
            brg_gnt      = link_gnt;
        end else begin
            gnt_pin_n = ~owner[NR-1:1];
            brg_gnt   = owner[0];
        end
    end

endmodule

// File: rtl/pci_tier_arbiter_chk.sv
// Module: property checker for the arbiter, bound to the top module.
// Assumes: frame_n is low only while the grant holder runs a transaction.
module pci_tier_arbiter_chk #(
    parameter int N_EXT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_arb_en,
    input logic [N_EXT:0]   tier_hi,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [N_EXT-1:0] req_pin_n,
    input logic [N_EXT-1:0] gnt_pin_n,
    input logic             brg_req,
    input logic             brg_gnt
);

    logic [N_EXT:0] gvec;
    logic           any_g;
    logic           seen_start_q;

    assign gvec  = {~gnt_pin_n, brg_gnt};
    assign any_g = |gvec;

    // Observer: frame seen low during the current ownership.
    always_ff @(posedge clk) begin
        if (!rst_n || !any_g) seen_start_q <= 1'b0;
        else if (!frame_n)    seen_start_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (&gnt_pin_n && !brg_gnt));

    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ext_arb_en)) |-> $onehot0(gvec));

    // R4
    handover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ext_arb_en) && !$past(ext_arb_en, 2) && any_g && $past(any_g))
        |-> gvec == $past(gvec));

    // R7
    withdraw_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ext_arb_en) && !$past(ext_arb_en, 2)
         && $past(any_g) && !any_g)
        |-> ($past(frame_n && irdy_n) || $past(seen_start_q)));

    // R8
    ext_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_arb_en)) |-> &gnt_pin_n[N_EXT-1:1]);

    // R9
    ext_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_arb_en))
        |-> (gnt_pin_n[0] == !$past(brg_req) && brg_gnt == !$past(req_pin_n[0])));

endmodule

bind pci_tier_arbiter pci_tier_arbiter_chk #(.N_EXT(N_EXT)) u_chk (.*);

// File: tb/pci_tier_arbiter_tb.sv
module pci_tier_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_arb_en = 1'b0;
    logic [NE:0]   tier_hi = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [NE-1:0] req_pin_n = '1;
    logic [NE-1:0] gnt_pin_n;
    logic          brg_req = 1'b0;
    logic          brg_gnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int seq [0:15];
    int seq_len;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pci_tier_arbiter #(.N_EXT(NE)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_arb_en (ext_arb_en),
        .tier_hi    (tier_hi),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .req_pin_n  (req_pin_n),
        .gnt_pin_n  (gnt_pin_n),
        .brg_req    (brg_req),
        .brg_gnt    (brg_gnt)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Current owner seen at the pins: -1 none, 0 bridge, k+1 pin k.
    function automatic int owner_now();
        if (brg_gnt) return 0;
        for (int k = 0; k < NE; k++) if (!gnt_pin_n[k]) return k + 1;
        return -1;
    endfunction

    function automatic int grant_count();
        return $countones(~gnt_pin_n) + int'(brg_gnt);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        // R1: all grants released under reset
        chk(gnt_pin_n == '1 && !brg_gnt, "R1", int'(gnt_pin_n), 511);
        rst_n = 1'b1;
    endtask

    // Run n cycles, record successive owners, check R3 and R4 each cycle.
    task automatic collect(input int n);
        int prev = -1;
        int bad3 = 0;
        int bad4 = 0;
        seq_len = 0;
        for (int c = 0; c < n; c++) begin
            int o;
            tick();
            o = owner_now();
            if (grant_count() > 1) bad3++;
            if (o >= 0 && prev >= 0 && o != prev) bad4++;
            if (o >= 0 && o != prev && seq_len < 16) begin
                seq[seq_len] = o;
                seq_len++;
            end
            prev = o;
        end
        chk(bad3 == 0, "R3", bad3, 0);
        chk(bad4 == 0, "R4", bad4, 0);
    endtask

    task automatic test_park_and_latency();
        req_pin_n = '1; brg_req = 1'b0; tier_hi = '1;
        do_reset();
        tick();
        chk(brg_gnt == 1'b1 && gnt_pin_n == '1, "R2", int'(brg_gnt), 1);
        req_pin_n[3] = 1'b0;
        tick();
        chk(owner_now() == -1, "R10", owner_now(), -1);
        tick();
        chk(owner_now() == 4, "R10", owner_now(), 4);
        req_pin_n = '1;
        tick();
        tick();
        chk(owner_now() == 0, "R2", owner_now(), 0);
    endtask

    task automatic test_upper_rotation();
        tier_hi = '1; brg_req = 1'b0;
        req_pin_n = 9'b1_1111_1000;
        do_reset();
        collect(12);
        chk(seq_len >= 6, "R5", seq_len, 6);
        for (int i = 0; i < 6; i++)
            chk(seq[i] == (i % 3) + 1, "R5", seq[i], (i % 3) + 1);
        req_pin_n = '1;
    endtask

    task automatic test_two_tiers();
        tier_hi = 10'b11_1110_0111;
        brg_req = 1'b0;
        req_pin_n = 9'b1_1111_0000;
        do_reset();
        collect(12);
        begin
            int exp6 [0:5] = '{1, 2, 3, 1, 2, 4};
            chk(seq_len >= 6, "R6", seq_len, 6);
            for (int i = 0; i < 6; i++)
                chk(seq[i] == exp6[i], "R6", seq[i], exp6[i]);
        end
        req_pin_n = '1;
        tier_hi = '1;
    endtask

    task automatic test_hold_until_start();
        tier_hi = '1; brg_req = 1'b0;
        req_pin_n = 9'b1_1111_1101;
        frame_n = 1'b1; irdy_n = 1'b1;
        do_reset();
        tick();
        chk(owner_now() == 2, "R7", owner_now(), 2);
        irdy_n = 1'b0;
        req_pin_n[4] = 1'b0;
        tick(); tick(); tick();
        chk(owner_now() == 2, "R7", owner_now(), 2);
        frame_n = 1'b0;
        tick();
        chk(owner_now() == 2, "R7", owner_now(), 2);
        tick();
        chk(owner_now() == -1, "R7", owner_now(), -1);
        frame_n = 1'b1; irdy_n = 1'b1;
        tick();
        chk(owner_now() == 5, "R7", owner_now(), 5);
        req_pin_n = '1;
    endtask

    task automatic test_external();
        req_pin_n = '1; brg_req = 1'b0; tier_hi = '1;
        do_reset();
        tick();
        ext_arb_en = 1'b1;
        req_pin_n[2] = 1'b0;
        req_pin_n[7] = 1'b0;
        tick();
        chk(gnt_pin_n[8:1] == '1, "R8", int'(gnt_pin_n[8:1]), 255);
        chk(gnt_pin_n[0] == 1'b1 && !brg_gnt, "R9", int'(gnt_pin_n[0]), 1);
        brg_req = 1'b1;
        tick();
        chk(gnt_pin_n[0] == 1'b0, "R9", int'(gnt_pin_n[0]), 0);
        chk(!brg_gnt, "R9", int'(brg_gnt), 0);
        req_pin_n[0] = 1'b0;
        tick();
        chk(brg_gnt == 1'b1, "R9", int'(brg_gnt), 1);
        chk(gnt_pin_n[8:1] == '1, "R8", int'(gnt_pin_n[8:1]), 255);
        ext_arb_en = 1'b0;
        req_pin_n = '1;
        brg_req = 1'b0;
        tick();
    endtask

    task automatic test_reset_midway();
        req_pin_n = 9'b0_1111_1111; tier_hi = '1;
        tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        chk(gnt_pin_n == '1 && !brg_gnt, "R1", int'(gnt_pin_n), 511);
        rst_n = 1'b1;
        req_pin_n = '1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_park_and_latency();
        test_upper_rotation();
        test_two_tiers();
        test_hold_until_start();
        test_external();
        test_reset_midway();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule